// File: doc/BRIEF.md
# Idle-State Demotion Filter

This block sits on one core's path between the idle depth that core asks for and the depth that is handed to the power sequencer. It watches how long the core stayed in its last deep idle episode. When a deep request comes in before enough residency has built up, the block grants a shallower state. Once the residency is large enough, the deep request goes through unchanged. Short idle periods therefore stay out of the costly power-gated and clock-stopped states.

There are two demotion paths, and each has its own enable and its own residency threshold. The first turns power-gated requests into clock-stopped grants. The second turns any deep request, power-gated or clock-stopped, into a light-halt grant. Software programs both paths through a small write-only configuration port. Both paths are disabled after reset, so in that state every request is granted exactly as made.

Top module: `idle_demote`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `grant_valid_o` and `demoted_o` are low. Both demotion paths are disabled after reset.
- R2: While both enables are clear, every request is granted at the depth requested and `demoted_o` stays low.
- R3: Depth codes are 0 active, 1 light halt, 2 clock stopped and 3 power gated. Requests for codes 0 and 1 are always granted unchanged and never flagged.
- R4: A power-gated request (3) is granted as clock stopped (2) when the mid path is enabled, the halt rule does not apply and residency is below `thr_mid`. A grant is never deeper than its request.
- R5: A deep request (2 or 3) is granted as light halt (1) when the halt path is enabled and residency is below `thr_low`.
- R6: When both paths are enabled and residency is below both thresholds, a power-gated request is granted as light halt (1), not as clock stopped.
- R7: If residency is equal to or above the threshold of each enabled path that covers the request, the deep request is granted unchanged.
- R8: Residency counts the cycles `resident_deep_i` is high, as follows:
  - It loads 1 on the first high cycle of an episode.
  - It adds 1 on each further high cycle and saturates at 2^CNT_W-1.
  - It holds its value while `resident_deep_i` is low.
  - A request is judged on the count before that cycle's update.
- R9: `grant_valid_o` is high exactly in the cycle after each `req_valid_i`. `demoted_o` is high only in such a cycle, and only when the granted depth differs from the requested one.
- R10: Configuration writes use the following map. A write affects requests from the next cycle on.
  - Address 0: bit 0 enables the mid path (3 to 2) and bit 1 enables the halt path (deep to 1).
  - Address 1: the low CNT_W bits hold `thr_mid`.
  - Address 2: the low CNT_W bits hold `thr_low`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration register address |
| cfg_wdata_i | input | DATA_W | Configuration write data |
| req_valid_i | input | 1 | Idle request strobe |
| req_depth_i | input | 2 | Requested idle depth |
| resident_deep_i | input | 1 | Core currently resident in a deep idle state |
| grant_valid_o | output | 1 | Grant strobe, one cycle after the request |
| grant_depth_o | output | 2 | Granted idle depth |
| demoted_o | output | 1 | Grant is shallower than the request |

## Verification
The assertions take two things for granted:
- A request's depth is stable in the cycle its strobe is high.
- `resident_deep_i` is a clean level that changes only between clock edges.

The bench drives every input 2 ns after a rising edge, so both conditions hold. It also lets requests arrive at any point within or between deep episodes. Threshold and enable writes are sometimes placed in the same cycle as a request, which exercises the next-cycle rule. A stretch of random stimulus follows the directed cases. It does not break these conditions, because every draw is still applied on the same post-edge schedule.

// File: rtl/idle_demote_pkg.sv
package idle_demote_pkg;
  typedef enum logic [1:0] {
    DEPTH_ACTIVE = 2'd0,
    DEPTH_HALT   = 2'd1,
    DEPTH_STOP   = 2'd2,
    DEPTH_GATE   = 2'd3
  } depth_e;

  localparam logic [1:0] CFG_ADDR_EN      = 2'd0;
  localparam logic [1:0] CFG_ADDR_THR_MID = 2'd1;
  localparam logic [1:0] CFG_ADDR_THR_LOW = 2'd2;
endpackage

// File: rtl/idle_demote_cfg.sv
module idle_demote_cfg
  import idle_demote_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_mid_o,
  output logic              en_low_o,
  output logic [CNT_W-1:0]  thr_mid_o,
  output logic [CNT_W-1:0]  thr_low_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_mid_o  <= 1'b0;
      en_low_o  <= 1'b0;
      thr_mid_o <= '0;
      thr_low_o <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        CFG_ADDR_EN: begin
          en_mid_o <= wdata_i[0];
          en_low_o <= wdata_i[1];
        end
        CFG_ADDR_THR_MID: thr_mid_o <= wdata_i[CNT_W-1:0];
        CFG_ADDR_THR_LOW: thr_low_o <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // R10
  enables_written_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == CFG_ADDR_EN |=> en_mid_o == $past(wdata_i[0]) && en_low_o == $past(wdata_i[1]));
endmodule

// File: rtl/idle_demote_resid.sv
module idle_demote_resid #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             deep_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      count_o <= '0;
    end else begin
      prev_q <= deep_i;
      if (deep_i && !prev_q)        count_o <= CNT_W'(1);
      else if (deep_i && count_o != CNT_MAX) count_o <= count_o + 1'b1;
    end
  end

  // R8
  episode_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deep_i) |=> count_o == CNT_W'(1));
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deep_i |=> $stable(count_o));
  // R8
  saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deep_i && prev_q && count_o == CNT_MAX |=> count_o == CNT_MAX);
endmodule

// File: rtl/idle_demote_policy.sv
module idle_demote_policy
  import idle_demote_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  depth_e           req_depth_i,
  input  logic [CNT_W-1:0] resid_i,
  input  logic             en_mid_i,
  input  logic             en_low_i,
  input  logic [CNT_W-1:0] thr_mid_i,
  input  logic [CNT_W-1:0] thr_low_i,
  output logic             grant_valid_o,
  output depth_e           grant_depth_o,
  output logic             demoted_o
);
  logic   below_low, below_mid;
  depth_e decided;

  assign below_low = en_low_i && (resid_i < thr_low_i);
  assign below_mid = en_mid_i && (resid_i < thr_mid_i);

  always_comb begin
    decided = req_depth_i;
    unique case (req_depth_i)
      DEPTH_GATE: if (below_low) decided = DEPTH_HALT;
                  else if (below_mid) decided = DEPTH_STOP;
      DEPTH_STOP: if (below_low) decided = DEPTH_HALT;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_depth_o <= DEPTH_ACTIVE;
      demoted_o     <= 1'b0;
    end else begin
      grant_valid_o <= req_valid_i;
      demoted_o     <= req_valid_i && (decided != req_depth_i);
      if (req_valid_i) grant_depth_o <= decided;
    end
  end

  // R9
  flag_needs_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    demoted_o |-> grant_valid_o);
  // R3
  shallow_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_depth_i <= DEPTH_HALT |=> grant_depth_o == $past(req_depth_i) && !demoted_o);
  // R2
  disabled_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !en_mid_i && !en_low_i |=> !demoted_o);
  // R4
  never_deeper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> grant_depth_o <= $past(req_depth_i));
  // R6
  halt_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_depth_i >= DEPTH_STOP && en_low_i && resid_i < thr_low_i
    |=> grant_depth_o == DEPTH_HALT);
endmodule

// File: rtl/idle_demote.sv
module idle_demote
  import idle_demote_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_depth_i,
  input  logic              resident_deep_i,
  output logic              grant_valid_o,
  output logic [1:0]        grant_depth_o,
  output logic              demoted_o
);
  logic             en_mid, en_low;
  logic [CNT_W-1:0] thr_mid, thr_low, resid;
  depth_e           grant_depth;

  idle_demote_cfg #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .en_mid_o  (en_mid),
    .en_low_o  (en_low),
    .thr_mid_o (thr_mid),
    .thr_low_o (thr_low)
  );

  idle_demote_resid #(.CNT_W(CNT_W)) u_resid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .deep_i  (resident_deep_i),
    .count_o (resid)
  );

  idle_demote_policy #(.CNT_W(CNT_W)) u_policy (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_depth_i   (depth_e'(req_depth_i)),
    .resid_i       (resid),
    .en_mid_i      (en_mid),
    .en_low_i      (en_low),
    .thr_mid_i     (thr_mid),
    .thr_low_i     (thr_low),
    .grant_valid_o (grant_valid_o),
    .grant_depth_o (grant_depth),
    .demoted_o     (demoted_o)
  );

  assign grant_depth_o = grant_depth;

  // R9
  grant_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> grant_valid_o);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |=> !grant_valid_o && !demoted_o);
endmodule

// File: tb/idle_demote_test.sv
`timescale 1ns/1ps
module idle_demote_test;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;
  localparam int MAXC   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_addr = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_depth = '0;
  logic              deep = 1'b0;
  logic              grant_valid, demoted;
  logic [1:0]        grant_depth;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_res = 0, m_prev = 0, m_en_mid = 0, m_en_low = 0, m_thr_mid = 0, m_thr_low = 0;
  int e_valid = 0, e_depth = 0, e_dem = 0;
  string e_tag = "R9", force_tag = "";

  always #5 clk = ~clk;

  idle_demote #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .req_valid_i(req_valid), .req_depth_i(req_depth),
    .resident_deep_i(deep), .grant_valid_o(grant_valid), .grant_depth_o(grant_depth),
    .demoted_o(demoted)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_res = 0; m_prev = 0; m_en_mid = 0; m_en_low = 0; m_thr_mid = 0; m_thr_low = 0;
      e_valid = 0; e_depth = 0; e_dem = 0; e_tag = "R1";
    end else begin
      e_valid = req_valid;
      e_depth = req_depth;
      if (req_valid && req_depth >= 2) begin
        if (m_en_low && m_res < m_thr_low) e_depth = 1;
        else if (req_depth == 3 && m_en_mid && m_res < m_thr_mid) e_depth = 2;
      end
      e_dem = req_valid && (e_depth != req_depth);
      if (!req_valid)                    e_tag = "R9";
      else if (req_depth <= 1)           e_tag = "R3";
      else if (!m_en_mid && !m_en_low)   e_tag = "R2";
      else if (e_depth == 1 && req_depth == 3 && m_en_mid && m_res < m_thr_mid) e_tag = "R6";
      else if (e_depth == 1)             e_tag = "R5";
      else if (e_depth == 2 && e_dem)    e_tag = "R4";
      else if (m_res == MAXC)            e_tag = "R8";
      else                               e_tag = "R7";
      if (force_tag != "" && req_valid) begin e_tag = force_tag; force_tag = ""; end
      if (deep && !m_prev) m_res = 1;
      else if (deep && m_res < MAXC) m_res = m_res + 1;
      m_prev = deep;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: begin m_en_mid = cfg_wdata[0]; m_en_low = cfg_wdata[1]; end
          2'd1: m_thr_mid = int'(cfg_wdata[CNT_W-1:0]);
          2'd2: m_thr_low = int'(cfg_wdata[CNT_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(grant_valid == e_valid[0], e_tag, grant_valid, e_valid);
    chk(demoted == e_dem[0], e_tag, demoted, e_dem);
    if (e_valid) chk(grant_depth == e_depth[1:0], e_tag, grant_depth, e_depth);
  endtask

  task automatic tick();
    @(posedge clk); #2;
    compare();
    cfg_we = 1'b0; req_valid = 1'b0;
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = DATA_W'(d);
    tick();
  endtask

  task automatic request(int d);
    req_valid = 1'b1; req_depth = 2'(d);
    tick();
    tick();
  endtask

  task automatic episode(int n);
    deep = 1'b1;
    repeat (n) tick();
    deep = 1'b0;
    tick();
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    chk(grant_valid == 1'b0, "R1", grant_valid, 0);
    chk(demoted == 1'b0, "R1", demoted, 0);
    rst_n = 1'b1;
    tick();
    chk(grant_valid == 1'b0 && demoted == 1'b0, "R1", {grant_valid, demoted}, 0);
    // R2, R3: disabled after reset, all depths pass
    for (int d = 0; d < 4; d++) request(d);
    episode(2);
    request(3);
    // R10: same-cycle request sees old config, next one sees new
    wr(1, 20);
    wr(2, 5);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 1;
    req_valid = 1'b1; req_depth = 2'd3;
    tick();
    force_tag = "R10";
    request(3);
    // R4 / R7 with mid path only
    episode(10);
    request(3);
    request(2);
    // R6 / R5 / R4 with both paths
    wr(0, 3);
    episode(3);
    request(3);
    request(2);
    episode(7);
    request(3);
    episode(20);
    request(3);
    request(2);
    // R5 with halt path only
    wr(0, 2);
    wr(2, 30);
    request(3);
    request(2);
    request(1);
    request(0);
    // R8: saturation boundary
    wr(0, 3);
    wr(1, MAXC);
    wr(2, MAXC);
    episode(MAXC - 1);
    request(3);
    episode(MAXC + 40);
    request(3);
    request(2);
    // request during an episode (R8: judged on pre-update count)
    wr(2, 4);
    deep = 1'b1;
    tick(); tick(); tick();
    req_valid = 1'b1; req_depth = 2'd2;
    tick(); tick();
    deep = 1'b0;
    tick();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      deep = ($urandom_range(0, 9) < 6);
      req_valid = ($urandom_range(0, 3) == 0);
      req_depth = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) begin
        cfg_we = 1'b1;
        cfg_addr = 2'($urandom_range(0, 3));
        cfg_wdata = DATA_W'($urandom_range(0, 40));
      end
      tick();
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule